// File: doc/BRIEF.md
# Serial Controller Status and Control Register Bank

This block is the register bank of a serial controller that has a receive FIFO. It sits between a simple word-strobed register bus and the transmit and receive datapaths, which live elsewhere. It holds the configuration registers: line mode, bit-rate divisor, control, FIFO control and port pins. Each register applies its own write mask. The block also keeps five sticky status flags and drives the transmit and receive interrupt levels.

Software clears a status flag by writing 0 to its bit; writing 1 leaves the flag alone. Hardware sets flags from event inputs (break seen, receive threshold reached, data ready) and from bus activity. Writing the transmit data register consumes the transmit-empty condition. A status read taken while the transmitter is enabled sets both transmit flags again. The receive FIFO and the shifters stay outside the block. The block passes them the transmit byte, a pop pulse, a flush pulse and the decoded receive trigger level, and it reads back the received byte and the FIFO fill count.

Top module: `ssc_regbank`

## Requirements
- R1: After reset: mode register 0x00, bit-rate 0xFF, control 0x20, port 0x00, FIFO control 0x0000, trigger level 1, both interrupts low. The status word reads 0x60, meaning transmit-end and transmit-empty are set and the other flags are clear.
- R2: A write to byte offset 0x00 stores the data ANDed with 0x7B. A write to 0x08 (control) stores the data ANDed with 0xFA. A write to 0x20 (port) stores the data ANDed with 0xF3. Bit-rate (0x04) and FIFO control (0x18) store the written data unmasked. Every register reads back at its own offset.
- R3: A read strobe updates bus_rdata on the next rising edge, and bus_rdata holds that value until the next read. A status read (0x10) returns data-ready in bit 0, receive-full in bit 1, break in bit 4, transmit-empty in bit 5 and transmit-end in bit 6, with all other bits 0.
- R4: A status write clears each of the five flags whose bit position is written as 0. Flags whose bit is written as 1 keep their value.
- R5: When a flag's set condition and its write-0 clear occur in the same cycle, the flag ends up set.
- R6: A write to 0x0C clears transmit-empty, drives tx_data with the low byte and pulses tx_load for one cycle on the next edge.
- R7: A status read while control bit 5 (transmit enable) is 1 sets transmit-empty and transmit-end after the read. The word returned is the value from before the read.
- R8: A control write with bit 5 at 0 sets transmit-end.
- R9: brk_evt sets break, rx_full_evt sets receive-full and rx_ready_evt sets data-ready, each on the next edge.
- R10: rx_irq rises on the edge after rx_full_evt if control bit 6 is 1 at that time. It falls after a status write that has bit 0 or bit 1 at 0, or after a control write with bit 6 at 0. A same-cycle set wins over a clear.
- R11: tx_irq equals control bit 7 from the edge after a control write onward.
- R12: A FIFO-control write sets rx_trig from bits 7:6 (0→1, 1→4, 2→8, 3→14). It pulses fifo_flush for one cycle when bit 1 is 1.
- R13: A read of 0x14 returns rx_data and pulses rx_pop for one cycle. A read of 0x1C returns rx_level.
- R14: Reads of 0x0C, of line status 0x24, of offsets not on a 4-byte boundary and of offsets above 0x24 return 0. Writes to 0x14, 0x1C, 0x24, to misaligned offsets and to offsets above 0x24 change no register, flag or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe (one cycle per access) |
| bus_rd | input | 1 | Register read strobe, never together with bus_wr |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| brk_evt | input | 1 | Break condition detected |
| rx_full_evt | input | 1 | Receive FIFO reached its trigger level |
| rx_ready_evt | input | 1 | Receive data is ready |
| rx_data | input | 8 | Byte at the head of the receive FIFO |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_pop | output | 1 | Pulse: receive data register read |
| fifo_flush | output | 1 | Pulse: receive FIFO flush requested |
| rx_trig | output | 5 | Decoded receive trigger level |
| tx_data | output | 8 | Last byte written for transmission |
| tx_load | output | 1 | Pulse: new transmit byte written |
| mode_q | output | 8 | Line mode register |
| brate_q | output | 8 | Bit-rate divisor register |
| ctrl_q | output | 8 | Control register |
| port_q | output | 8 | Port register |
| tx_irq | output | 1 | Transmit interrupt level |
| rx_irq | output | 1 | Receive interrupt level |

## Verification
A flag that is wrong inside the block shows up in the word returned by the next status read, one cycle after the strobe. It can also appear sooner through rx_irq, which follows the receive-full and data-ready clears. A wrong configuration register is visible at its output port on the edge after the write. A lost or inverted set-over-clear priority only shows at the first status read taken after the collision, so the stimulus mixes event pulses into the same cycles as status writes and reads. A model in the bench compares every output after every access.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
  localparam int REG_W = 8;

  // register slots; byte offset = slot * 4
  localparam int IDX_MODE  = 0;
  localparam int IDX_BRATE = 1;
  localparam int IDX_CTRL  = 2;
  localparam int IDX_TXD   = 3;
  localparam int IDX_STAT  = 4;
  localparam int IDX_RXD   = 5;
  localparam int IDX_FCTL  = 6;
  localparam int IDX_LVL   = 7;
  localparam int IDX_PORT  = 8;
  localparam int IDX_LINE  = 9;
  localparam int NUM_REGS  = 10;

  // sticky flag indices
  localparam int FL_DR     = 0;
  localparam int FL_RF     = 1;
  localparam int FL_BRK    = 2;
  localparam int FL_TDE    = 3;
  localparam int FL_TEND   = 4;
  localparam int NUM_FLAGS = 5;

  localparam int CTL_TXEN = 5;
  localparam int CTL_RXIE = 6;
  localparam int CTL_TXIE = 7;
  localparam int FCR_FLUSH    = 1;
  localparam int FCR_TRIG_LSB = 6;

  localparam logic [REG_W-1:0] MODE_MASK = 8'h7B;
  localparam logic [REG_W-1:0] CTRL_MASK = 8'hFA;
  localparam logic [REG_W-1:0] PORT_MASK = 8'hF3;
  localparam logic [REG_W-1:0] CTRL_RST  = 8'h20;
  localparam logic [REG_W-1:0] BRATE_RST = 8'hFF;

  // position of each flag inside the status word
  function automatic int stat_bit(input int fl);
    case (fl)
      FL_DR:   return 0;
      FL_RF:   return 1;
      FL_BRK:  return 4;
      FL_TDE:  return 5;
      default: return 6;
    endcase
  endfunction

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 5'd1;
      2'd1:    return 5'd4;
      2'd2:    return 5'd8;
      default: return 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/ssc_decode.sv
module ssc_decode #(
  parameter int ADDR_W   = 6,
  parameter int NUM_SLOT = 10
) (
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic [NUM_SLOT-1:0] wr_sel,
  output logic [NUM_SLOT-1:0] rd_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] slot;

  assign aligned = (bus_addr[1:0] == 2'b00);
  assign slot    = bus_addr[ADDR_W-1:2];

  for (genvar g = 0; g < NUM_SLOT; g++) begin : g_slot
    logic hit;
    assign hit       = aligned && (slot == IDX_W'(g));
    assign wr_sel[g] = bus_wr && hit;
    assign rd_sel[g] = bus_rd && hit;
  end
endmodule

// File: rtl/ssc_cfg_regs.sv
module ssc_cfg_regs
  import ssc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FCR_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mode,
  input  logic              wr_brate,
  input  logic              wr_ctrl,
  input  logic              wr_fcr,
  input  logic              wr_port,
  input  logic [DATA_W-1:0] wdata,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  brate_q,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [FCR_W-1:0]  fcr_q,
  output logic [REG_W-1:0]  port_q,
  output logic [4:0]        trig_q,
  output logic              flush_q
);
  logic [REG_W-1:0] wbyte;
  assign wbyte = wdata[REG_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= '0;
      brate_q <= BRATE_RST;
      ctrl_q  <= CTRL_RST;
      fcr_q   <= '0;
      port_q  <= '0;
      trig_q  <= 5'd1;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_fcr && wdata[FCR_FLUSH];
      if (wr_mode)  mode_q  <= wbyte & MODE_MASK;
      if (wr_brate) brate_q <= wbyte;
      if (wr_ctrl)  ctrl_q  <= wbyte & CTRL_MASK;
      if (wr_port)  port_q  <= wbyte & PORT_MASK;
      if (wr_fcr) begin
        fcr_q  <= wdata[FCR_W-1:0];
        trig_q <= trig_level(wdata[FCR_TRIG_LSB +: 2]);
      end
    end
  end

  // R2: control keeps only the masked bits of the written byte
  p_ctrl_mask_r2: assert property (@(posedge clk) disable iff (rst)
    wr_ctrl |=> ctrl_q == ($past(wbyte) & CTRL_MASK));

  // R12: a flush pulse only follows a FIFO-control write
  p_flush_src_r12: assert property (@(posedge clk) disable iff (rst)
    flush_q |-> $past(wr_fcr));
endmodule

// File: rtl/ssc_flags.sv
module ssc_flags
  import ssc_pkg::*;
#(
  parameter int                 NFLAG   = 5,
  parameter logic [NFLAG-1:0]   RST_VEC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NFLAG-1:0] set_vec,
  input  logic [NFLAG-1:0] clr_vec,
  input  logic             irq_set,
  input  logic             irq_clr,
  output logic [NFLAG-1:0] flags_q,
  output logic             rx_irq_q
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)             flags_q[g] <= RST_VEC[g];
      else if (set_vec[g]) flags_q[g] <= 1'b1;
      else if (clr_vec[g]) flags_q[g] <= 1'b0;
    end

    // R5: a set request always lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (rst)
      set_vec[g] |=> flags_q[g]);

    // R4: an uncontested clear drops the flag
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
      (clr_vec[g] && !set_vec[g]) |=> !flags_q[g]);

    // R4: without a request the flag holds
    p_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (!clr_vec[g] && !set_vec[g]) |=> $stable(flags_q[g]));
  end

  always_ff @(posedge clk) begin
    if (rst)          rx_irq_q <= 1'b0;
    else if (irq_set) rx_irq_q <= 1'b1;
    else if (irq_clr) rx_irq_q <= 1'b0;
  end

  // R10: receive interrupt set has priority
  p_rxirq_set_r10: assert property (@(posedge clk) disable iff (rst)
    irq_set |=> rx_irq_q);
endmodule

// File: rtl/ssc_regbank.sv
module ssc_regbank
  import ssc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int FCR_W  = 16,
  parameter int LVL_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              brk_evt,
  input  logic              rx_full_evt,
  input  logic              rx_ready_evt,
  input  logic [7:0]        rx_data,
  input  logic [LVL_W-1:0]  rx_level,
  output logic              rx_pop,
  output logic              fifo_flush,
  output logic [4:0]        rx_trig,
  output logic [7:0]        tx_data,
  output logic              tx_load,
  output logic [7:0]        mode_q,
  output logic [7:0]        brate_q,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        port_q,
  output logic              tx_irq,
  output logic              rx_irq
);
  localparam logic [NUM_FLAGS-1:0] FLAG_RST =
    NUM_FLAGS'((1 << FL_TEND) | (1 << FL_TDE));

  logic [NUM_REGS-1:0]  wr_sel, rd_sel;
  logic [FCR_W-1:0]     fcr_q;
  logic [NUM_FLAGS-1:0] set_vec, clr_vec, flags_q;
  logic                 irq_set, irq_clr;
  logic                 stat_wr, stat_rd, txd_wr, ctrl_wr;
  logic [DATA_W-1:0]    stat_word, rd_word;
  logic [DATA_W-1:0]    rd_val [NUM_REGS];
  logic                 unused_wr;

  ssc_decode #(.ADDR_W(ADDR_W), .NUM_SLOT(NUM_REGS)) u_dec (
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .wr_sel(wr_sel), .rd_sel(rd_sel)
  );

  // read-only and empty slots take no writes
  assign unused_wr = ^{wr_sel[IDX_RXD], wr_sel[IDX_LVL], wr_sel[IDX_LINE]};

  ssc_cfg_regs #(.DATA_W(DATA_W), .FCR_W(FCR_W)) u_cfg (
    .clk(clk), .rst(rst),
    .wr_mode(wr_sel[IDX_MODE]), .wr_brate(wr_sel[IDX_BRATE]),
    .wr_ctrl(wr_sel[IDX_CTRL]), .wr_fcr(wr_sel[IDX_FCTL]),
    .wr_port(wr_sel[IDX_PORT]), .wdata(bus_wdata),
    .mode_q(mode_q), .brate_q(brate_q), .ctrl_q(ctrl_q),
    .fcr_q(fcr_q), .port_q(port_q), .trig_q(rx_trig), .flush_q(fifo_flush)
  );

  assign stat_wr = wr_sel[IDX_STAT];
  assign stat_rd = rd_sel[IDX_STAT];
  assign txd_wr  = wr_sel[IDX_TXD];
  assign ctrl_wr = wr_sel[IDX_CTRL];

  // flag set sources
  always_comb begin
    set_vec          = '0;
    set_vec[FL_DR]   = rx_ready_evt;
    set_vec[FL_RF]   = rx_full_evt;
    set_vec[FL_BRK]  = brk_evt;
    set_vec[FL_TDE]  = stat_rd && ctrl_q[CTL_TXEN];
    set_vec[FL_TEND] = (ctrl_wr && !bus_wdata[CTL_TXEN]) ||
                       (stat_rd && ctrl_q[CTL_TXEN]);
  end

  // flag clear sources: write-0 on the flag's status bit
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_clr
    if (g == FL_TDE) begin : g_tde
      assign clr_vec[g] = (stat_wr && !bus_wdata[stat_bit(g)]) || txd_wr;
    end else begin : g_oth
      assign clr_vec[g] = stat_wr && !bus_wdata[stat_bit(g)];
    end
  end

  assign irq_set = rx_full_evt && ctrl_q[CTL_RXIE];
  assign irq_clr = (stat_wr && (!bus_wdata[stat_bit(FL_RF)] ||
                                !bus_wdata[stat_bit(FL_DR)])) ||
                   (ctrl_wr && !bus_wdata[CTL_RXIE]);

  ssc_flags #(.NFLAG(NUM_FLAGS), .RST_VEC(FLAG_RST)) u_flags (
    .clk(clk), .rst(rst), .set_vec(set_vec), .clr_vec(clr_vec),
    .irq_set(irq_set), .irq_clr(irq_clr),
    .flags_q(flags_q), .rx_irq_q(rx_irq)
  );

  assign tx_irq = ctrl_q[CTL_TXIE];

  always_comb begin
    stat_word = '0;
    for (int i = 0; i < NUM_FLAGS; i++) stat_word[stat_bit(i)] = flags_q[i];
  end

  always_comb begin
    rd_val[IDX_MODE]  = DATA_W'(mode_q);
    rd_val[IDX_BRATE] = DATA_W'(brate_q);
    rd_val[IDX_CTRL]  = DATA_W'(ctrl_q);
    rd_val[IDX_TXD]   = '0;
    rd_val[IDX_STAT]  = stat_word;
    rd_val[IDX_RXD]   = DATA_W'(rx_data);
    rd_val[IDX_FCTL]  = DATA_W'(fcr_q);
    rd_val[IDX_LVL]   = DATA_W'(rx_level);
    rd_val[IDX_PORT]  = DATA_W'(port_q);
    rd_val[IDX_LINE]  = '0;
    rd_word = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (rd_sel[i]) rd_word = rd_word | rd_val[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_data   <= '0;
      tx_load   <= 1'b0;
      rx_pop    <= 1'b0;
    end else begin
      tx_load <= txd_wr;
      rx_pop  <= rd_sel[IDX_RXD];
      if (txd_wr) tx_data   <= bus_wdata[7:0];
      if (bus_rd) bus_rdata <= rd_word;
    end
  end

  // R3: one strobe per cycle on the bus
  p_bus_excl_r3: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));

  // R6: a transmit-data write consumes transmit-empty
  p_tde_txw_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(IDX_TXD * 4)) |=> !flags_q[FL_TDE]);

  // R7: status read with transmitter enabled re-arms both transmit flags
  p_stat_rd_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(IDX_STAT * 4) && ctrl_q[CTL_TXEN])
    |=> (flags_q[FL_TDE] && flags_q[FL_TEND]));

  // R11: transmit interrupt follows the written enable bit
  p_txirq_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == ADDR_W'(IDX_CTRL * 4))
    |=> tx_irq == $past(bus_wdata[CTL_TXIE]));

  // R14: misaligned reads return zero
  p_misaligned_r14: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[1:0] != 2'b00) |=> bus_rdata == '0);
endmodule

// File: tb/sim_ssc_regbank.sv
`timescale 1ns/1ps
module sim_ssc_regbank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 0, bus_rd = 0;
  logic [5:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        brk_evt = 0, rx_full_evt = 0, rx_ready_evt = 0;
  logic [7:0]  rx_data = '0;
  logic [4:0]  rx_level = '0;
  logic        rx_pop, fifo_flush, tx_load, tx_irq, rx_irq;
  logic [4:0]  rx_trig;
  logic [7:0]  tx_data, mode_q, brate_q, ctrl_q, port_q;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ssc_regbank u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .brk_evt(brk_evt), .rx_full_evt(rx_full_evt), .rx_ready_evt(rx_ready_evt),
    .rx_data(rx_data), .rx_level(rx_level), .rx_pop(rx_pop),
    .fifo_flush(fifo_flush), .rx_trig(rx_trig), .tx_data(tx_data),
    .tx_load(tx_load), .mode_q(mode_q), .brate_q(brate_q), .ctrl_q(ctrl_q),
    .port_q(port_q), .tx_irq(tx_irq), .rx_irq(rx_irq)
  );

  // reference model state
  logic [7:0]  m_mode, m_brate, m_ctrl, m_port, m_txd;
  logic [15:0] m_fcr;
  logic [4:0]  m_trig;
  logic        m_tend, m_tde, m_brk, m_rf, m_dr, m_irq;

  task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_trig(input logic [1:0] s);
    return (s == 0) ? 5'd1 : (s == 1) ? 5'd4 : (s == 2) ? 5'd8 : 5'd14;
  endfunction

  function automatic logic [15:0] exp_stat();
    return {9'd0, m_tend, m_tde, m_brk, 2'b00, m_rf, m_dr};
  endfunction

  function automatic logic [15:0] exp_read(input logic [5:0] a);
    if (a[1:0] != 0) return 16'h0;
    case (a)
      6'h00: return {8'h0, m_mode};
      6'h04: return {8'h0, m_brate};
      6'h08: return {8'h0, m_ctrl};
      6'h10: return exp_stat();
      6'h14: return {8'h0, rx_data};
      6'h18: return m_fcr;
      6'h1C: return {11'h0, rx_level};
      6'h20: return {8'h0, m_port};
      default: return 16'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_mode = 0; m_brate = 8'hFF; m_ctrl = 8'h20; m_port = 0; m_txd = 0;
    m_fcr = 0; m_trig = 1;
    m_tend = 1; m_tde = 1; m_brk = 0; m_rf = 0; m_dr = 0; m_irq = 0;
  endtask

  // one bus cycle plus optional events, then compare every output
  task automatic do_op(input bit w, input bit r, input logic [5:0] a,
                       input logic [15:0] d, input bit b, input bit f,
                       input bit y);
    logic [15:0] er;
    bit sw, sr, cw, tw, fw, rxr;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    brk_evt = b; rx_full_evt = f; rx_ready_evt = y;
    rx_data = 8'($urandom); rx_level = 5'($urandom_range(0, 16));
    er  = exp_read(a);
    sw  = w && a == 6'h10; sr = r && a == 6'h10; cw = w && a == 6'h08;
    tw  = w && a == 6'h0C; fw = w && a == 6'h18; rxr = r && a == 6'h14;
    // flags: set beats clear
    begin
      bit t_set, e_set;
      t_set = (cw && !d[5]) || (sr && m_ctrl[5]);
      e_set = sr && m_ctrl[5];
      m_tend = t_set | (m_tend & !(sw && !d[6]));
      m_tde  = e_set | (m_tde & !((sw && !d[5]) || tw));
      m_brk  = b | (m_brk & !(sw && !d[4]));
      m_rf   = f | (m_rf & !(sw && !d[1]));
      m_dr   = y | (m_dr & !(sw && !d[0]));
      m_irq  = (f && m_ctrl[6]) |
               (m_irq & !((sw && (!d[1] || !d[0])) || (cw && !d[6])));
    end
    if (w && a == 6'h00) m_mode  = d[7:0] & 8'h7B;
    if (w && a == 6'h04) m_brate = d[7:0];
    if (cw)              m_ctrl  = d[7:0] & 8'hFA;
    if (w && a == 6'h20) m_port  = d[7:0] & 8'hF3;
    if (fw) begin m_fcr = d; m_trig = exp_trig(d[7:6]); end
    if (tw) m_txd = d[7:0];
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; brk_evt = 0; rx_full_evt = 0; rx_ready_evt = 0;
    if (r) begin
      if (a == 6'h10)
        chk(bus_rdata == er, "R3 R4 R5 R7 R8 R9 status read", bus_rdata, er);
      else if (a == 6'h14 || a == 6'h1C)
        chk(bus_rdata == er, "R13 rx data/level read", bus_rdata, er);
      else if (a[1:0] != 0 || a >= 6'h24 || a == 6'h0C)
        chk(bus_rdata == er, "R14 empty offset read", bus_rdata, er);
      else
        chk(bus_rdata == er, "R2 register readback", bus_rdata, er);
    end
    chk({mode_q, brate_q} == {m_mode, m_brate}, "R2 R14 mode/brate",
        {mode_q, brate_q}, {m_mode, m_brate});
    chk({ctrl_q, port_q} == {m_ctrl, m_port}, "R2 R14 ctrl/port",
        {ctrl_q, port_q}, {m_ctrl, m_port});
    chk(tx_irq == m_ctrl[7], "R11 tx_irq", 16'(tx_irq), 16'(m_ctrl[7]));
    chk(rx_irq == m_irq, "R10 rx_irq", 16'(rx_irq), 16'(m_irq));
    chk({tx_load, tx_data} == {tw, m_txd}, "R6 tx_load/tx_data",
        16'({tx_load, tx_data}), 16'({tw, m_txd}));
    chk(rx_pop == rxr, "R13 rx_pop", 16'(rx_pop), 16'(rxr));
    chk({fifo_flush, rx_trig} == {fw && d[1], m_trig}, "R12 flush/trigger",
        16'({fifo_flush, rx_trig}), 16'({fw && d[1], m_trig}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1: reset values at the ports
    chk({mode_q, brate_q, ctrl_q, port_q} == 32'h00FF2000 ? 1'b1 : 1'b0,
        "R1 reset config", {ctrl_q, port_q}, 16'h2000);
    chk(rx_trig == 5'd1 && !tx_irq && !rx_irq, "R1 reset trig/irq",
        16'({rx_trig, tx_irq, rx_irq}), 16'h0004);
    do_op(0, 1, 6'h10, 0, 0, 0, 0);                // R1: status 0x60
    do_op(0, 1, 6'h18, 0, 0, 0, 0);                // R1: FIFO control 0
    // directed corners
    do_op(1, 0, 6'h00, 16'hFFFF, 0, 0, 0);         // R2 mode mask
    do_op(1, 0, 6'h20, 16'h00FF, 0, 0, 0);         // R2 port mask
    do_op(1, 0, 6'h08, 16'h00C0, 0, 0, 0);         // R8, R11: tx off, irq enables
    do_op(0, 0, 6'h00, 0, 1, 1, 1);                // R9, R10 events
    do_op(1, 0, 6'h10, 16'h0000, 1, 0, 0);         // R5 break set beats clear
    do_op(0, 1, 6'h10, 0, 0, 0, 0);                // R4 R5 result
    do_op(1, 0, 6'h10, 16'hFFFF, 0, 1, 0);         // R4 write-1 no effect, R10
    do_op(1, 0, 6'h08, 16'h00A0, 0, 0, 0);         // R11 tx_irq on, rx irq off
    do_op(1, 0, 6'h0C, 16'h5A5A, 0, 0, 0);         // R6 tx write
    do_op(0, 1, 6'h10, 0, 0, 0, 0);                // R7 pre-read value
    do_op(0, 1, 6'h10, 0, 0, 0, 0);                // R7 post-read value
    for (int s = 0; s < 4; s++)
      do_op(1, 0, 6'h18, 16'((s << 6) | ((s & 1) << 1)), 0, 0, 0); // R12
    do_op(0, 1, 6'h14, 0, 0, 0, 0);                // R13
    do_op(0, 1, 6'h1C, 0, 0, 0, 0);                // R13
    do_op(1, 0, 6'h24, 16'hFFFF, 0, 0, 0);         // R14 ignored write
    do_op(1, 0, 6'h09, 16'h0000, 0, 0, 0);         // R14 misaligned write
    do_op(0, 1, 6'h24, 0, 0, 0, 0);                // R14
    do_op(0, 1, 6'h3C, 0, 0, 0, 0);                // R14
    // random mix
    for (int k = 0; k < 600; k++) begin
      int sl;
      logic [5:0] a;
      bit w, r;
      sl = $urandom_range(0, 11);
      a  = (sl >= 10) ? 6'($urandom_range(0, 63)) : 6'(sl * 4);
      w  = $urandom_range(0, 1) == 1;
      r  = !w && ($urandom_range(0, 3) != 0);
      do_op(w, r, a, 16'($urandom),
            $urandom_range(0, 7) == 0, $urandom_range(0, 5) == 0,
            $urandom_range(0, 5) == 0);
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule